// File: doc/BRIEF.md
# Emulated UART Transmit-Empty Status

This block generates the transmit-side empty flags of an emulated serial port. A host deposits characters, either into a single holding register (character mode, like a 16450) or into a transmit FIFO (FIFO mode, like a 16550). A local micro-controller then removes them. The FIFO storage is kept elsewhere. This block only watches the host write strobe, the micro-controller drain strobe and the FIFO fill level. From these it derives the flags that the host and the micro-controller read.

Two views of the holding-empty flag exist. The micro-controller view (`thre_mcu`) always updates at once. The host view (`thre_host`) can lag behind it on its rising edge by a programmable number of cycles when the transmit timer is on. The transmitter-empty flag (`temt_host`) follows the host holding-empty flag.

In FIFO mode the flag does not simply mirror "FIFO empty". Once the FIFO drains, the flag stays set until the host has refilled the FIFO to a programmable trigger level.

The controller has three states:
- `ST_EMPTY`: both views read 1.
- `ST_BUSY`: both views read 0.
- `ST_HOLD`: the micro-controller view reads 1 and the host view reads 0 while the delay timer counts.

The transitions are:
- **drain**: `ST_BUSY` goes to `ST_HOLD` when the timer is in use, or to `ST_EMPTY` otherwise.
- **expire**: `ST_HOLD` goes to `ST_EMPTY`.
- **fill**: `ST_EMPTY` or `ST_HOLD` goes to `ST_BUSY`.

Top module: `uart_txe_status`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `thre_host`, `temt_host` and `thre_mcu` are all 1, and the trigger-reached latch is 0.
- R2: In character mode (`fifo_mode`=0), a cycle with `host_wr`=1 makes `thre_host` and `thre_mcu` 0 after that clock edge. This holds from any state, including when `mcu_rd` is also 1 in the same cycle.
- R3: In character mode, a cycle with `mcu_rd`=1 and `host_wr`=0 while the holding register is occupied sets `thre_mcu` after that edge. With the timer unused, it also sets `thre_host` after that edge.
- R4: In FIFO mode (`fifo_mode`=1), a cycle with `fifo_level`=0 while the flags are clear sets `thre_mcu` after that edge. With the timer unused, it also sets `thre_host` after that edge.
- R5: In FIFO mode, the flags clear only in a cycle where `fifo_level` is at least the trigger level. The trigger level is 1, 4, 8 or 14 for `trig_sel` = 0, 1, 2 or 3. A lower nonzero level leaves the flags set. An internal latch records that the trigger level was reached and clears when the FIFO is empty.
- R6: With `timer_en`=1 and `tmr_len`=N>0, `thre_host` rises exactly N cycles after `thre_mcu` rises, and `thre_mcu` is not delayed. With `tmr_len`=0, there is no delay.
- R7: While a delayed set is pending, a fill event cancels it, and both flags are 0 after that edge. A fill event is a host write in character mode, or reaching the trigger level in FIFO mode.
- R8: `temt_host` always equals `thre_host`.
- R9: In character mode, `fifo_level` has no effect. In FIFO mode, `host_wr` and `mcu_rd` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 0: single holding register, 1: FIFO with trigger |
| trig_sel | input | 2 | Trigger level select: 0=1, 1=4, 2=8, 3=14 entries |
| timer_en | input | 1 | Enable delay of the host-visible set |
| tmr_len | input | TMR_W | Delay length in cycles (0 = no delay) |
| host_wr | input | 1 | Host write strobe to the holding register |
| mcu_rd | input | 1 | Micro-controller drain strobe of the holding register |
| fifo_level | input | LVL_W | Current transmit FIFO fill level |
| thre_host | output | 1 | Host-visible holding-empty flag |
| temt_host | output | 1 | Host-visible transmitter-empty flag |
| thre_mcu | output | 1 | Undelayed holding-empty flag seen by the micro-controller |

## Verification
Directed sequences exercise the following cases:
- Character-mode writes and drains, including a write and a drain in the same cycle. This separates write priority from drain priority.
- FIFO refills that stop one entry short of each trigger level and then reach it. This separates the trigger compare from a plain nonzero test.
- Timed drains followed by a fill inside the delay window and by no fill. This separates cancellation from expiry, and it checks the exact delay count against the undelayed micro-controller flag.

Seeded random phases alternate the two modes, with random timer settings and a random-walk FIFO level. During each phase the inputs that the active mode must ignore are toggled freely.

// File: rtl/txe_pkg.sv
package txe_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_BUSY  = 2'd1,
        ST_HOLD  = 2'd2
    } txe_state_e;

    // Trigger depth for each select code.
    function automatic logic [3:0] trig_depth(input logic [1:0] sel);
        logic [3:0] d;
        unique case (sel)
            2'd0:    d = 4'd1;
            2'd1:    d = 4'd4;
            2'd2:    d = 4'd8;
            default: d = 4'd14;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/txe_trig_detect.sv
module txe_trig_detect #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic [1:0]       trig_sel,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             trig_hit,
    output logic             lvl_zero,
    output logic             trig_seen,
    output logic [LVL_W-1:0] trig_val
);
    assign trig_val = LVL_W'(txe_pkg::trig_depth(trig_sel));
    assign trig_hit = fifo_mode && (fifo_level >= trig_val);
    assign lvl_zero = fifo_mode && (fifo_level == '0);

    // Remembers that the trigger level was met since the last empty event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_seen <= 1'b0;
        end else if (lvl_zero) begin
            trig_seen <= 1'b0;
        end else if (trig_hit) begin
            trig_seen <= 1'b1;
        end
    end

    assert_latch_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && fifo_level >= trig_val) |=> trig_seen);

    assert_latch_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && fifo_level == '0) |=> !trig_seen);

endmodule

// File: rtl/txe_delay_timer.sv
module txe_delay_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             cancel,
    input  logic [TMR_W-1:0] len,
    output logic             running,
    output logic             expire
);
    logic [TMR_W-1:0] cnt;

    assign expire = running && (cnt == TMR_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (cancel) begin
            running <= 1'b0;
        end else if (load) begin
            running <= (len != '0);
            cnt     <= len;
        end else if (running) begin
            if (cnt == TMR_W'(1)) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - TMR_W'(1);
            end
        end
    end

    assert_load_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !cancel && len != '0) |=> (running && cnt == $past(len)));

    assert_cancel_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !running);

endmodule

// File: rtl/uart_txe_status.sv
module uart_txe_status #(
    parameter int LVL_W = 5,
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic [1:0]       trig_sel,
    input  logic             timer_en,
    input  logic [TMR_W-1:0] tmr_len,
    input  logic             host_wr,
    input  logic             mcu_rd,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             thre_host,
    output logic             temt_host,
    output logic             thre_mcu
);
    import txe_pkg::*;

    txe_state_e       state, nxt;
    logic             trig_hit, lvl_zero, trig_seen;
    logic [LVL_W-1:0] trig_val;
    logic             tmr_running, tmr_expire;
    logic             fill_evt, drain_evt, use_tmr;
    logic             tmr_load, tmr_cancel;

    txe_trig_detect #(.LVL_W(LVL_W)) trig_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_mode),
        .trig_sel   (trig_sel),
        .fifo_level (fifo_level),
        .trig_hit   (trig_hit),
        .lvl_zero   (lvl_zero),
        .trig_seen  (trig_seen),
        .trig_val   (trig_val)
    );

    txe_delay_timer #(.TMR_W(TMR_W)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .cancel  (tmr_cancel),
        .len     (tmr_len),
        .running (tmr_running),
        .expire  (tmr_expire)
    );

    // Events seen through the active mode only.
    assign fill_evt  = fifo_mode ? trig_hit : host_wr;
    assign drain_evt = fifo_mode ? lvl_zero : (mcu_rd && !host_wr);
    assign use_tmr   = timer_en && (tmr_len != '0);

    // Next state and timer control.
    always_comb begin
        nxt        = state;
        tmr_load   = 1'b0;
        tmr_cancel = 1'b0;
        unique case (state)
            ST_BUSY: begin
                if (drain_evt) begin
                    nxt      = use_tmr ? ST_HOLD : ST_EMPTY;
                    tmr_load = use_tmr;
                end
            end
            ST_HOLD: begin
                if (fill_evt) begin
                    nxt        = ST_BUSY;
                    tmr_cancel = 1'b1;
                end else if (tmr_expire) begin
                    nxt = ST_EMPTY;
                end
            end
            ST_EMPTY: begin
                if (fill_evt) nxt = ST_BUSY;
            end
            default: nxt = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= nxt;
    end

    // Outputs.
    always_comb begin
        thre_host = (state == ST_EMPTY);
        temt_host = (state == ST_EMPTY);
        thre_mcu  = (state != ST_BUSY);
    end

    assert_reset_flags_R1: assert property (@(posedge clk)
        !rst_n |=> (thre_host && temt_host && thre_mcu && !trig_seen));

    assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && host_wr) |=> (!thre_mcu && !thre_host));

    assert_drain_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && mcu_rd && !host_wr) |=> thre_mcu);

    assert_empty_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && fifo_level == '0) |=> thre_mcu);

    assert_below_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && thre_mcu && fifo_level < trig_val) |=> thre_mcu);

    assert_host_after_mcu_R6: assert property (@(posedge clk) disable iff (!rst_n)
        thre_host |-> thre_mcu);

    assert_timer_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) == tmr_running);

    assert_temt_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        temt_host == thre_host);

endmodule

// File: tb/uart_txe_status_tb_top.sv
module uart_txe_status_tb_top;

    localparam int LVL_W = 5;
    localparam int TMR_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_mode = 1'b0;
    logic [1:0]       trig_sel = 2'd0;
    logic             timer_en = 1'b0;
    logic [TMR_W-1:0] tmr_len = '0;
    logic             host_wr = 1'b0;
    logic             mcu_rd = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic             thre_host, temt_host, thre_mcu;

    int n_cmp = 0;
    int n_bad = 0;
    int m_st  = 0;   // 0 empty, 1 occupied, 2 delayed set pending
    int m_cnt = 0;

    always #10 clk = ~clk;

    uart_txe_status #(.LVL_W(LVL_W), .TMR_W(TMR_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_mode),
        .trig_sel   (trig_sel),
        .timer_en   (timer_en),
        .tmr_len    (tmr_len),
        .host_wr    (host_wr),
        .mcu_rd     (mcu_rd),
        .fifo_level (fifo_level),
        .thre_host  (thre_host),
        .temt_host  (temt_host),
        .thre_mcu   (thre_mcu)
    );

    function automatic int trig_of(input logic [1:0] s);
        case (s)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "thre_host", thre_host, m_st == 0);
        chk(tag, "thre_mcu", thre_mcu, m_st != 1);
        chk("R8", "temt_host", temt_host, m_st == 0);
    endtask

    // One cycle: drive, advance the expected state, compare after the edge.
    task automatic cyc(input bit fm, input logic [1:0] ts, input bit te, input int tl,
                       input bit wr, input bit rd, input int lvl, input string tag);
        bit fill, drain;
        @(negedge clk);
        fifo_mode  = fm;
        trig_sel   = ts;
        timer_en   = te;
        tmr_len    = TMR_W'(tl);
        host_wr    = wr;
        mcu_rd     = rd;
        fifo_level = LVL_W'(lvl);
        fill  = fm ? (lvl >= trig_of(ts)) : wr;
        drain = fm ? (lvl == 0) : (rd && !wr);
        case (m_st)
            1: if (drain) begin
                   if (te && tl != 0) begin m_st = 2; m_cnt = tl; end
                   else m_st = 0;
               end
            2: if (fill) m_st = 1;
               else if (m_cnt == 1) m_st = 0;
               else m_cnt--;
            default: if (fill) m_st = 1;
        endcase
        @(posedge clk);
        #5;
        chk_all(tag);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int lvl;
        void'($urandom(32'h5EED));
        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        chk("R1", "thre_host", thre_host, 1'b1);
        chk("R1", "thre_mcu", thre_mcu, 1'b1);
        chk("R1", "temt_host", temt_host, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 0, 0, "R1");

        // R2 / R3: character mode, no timer
        cyc(0, 0, 0, 0, 1, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 1, 0, "R3");
        cyc(0, 0, 0, 0, 1, 1, 0, "R2");   // write wins over drain
        cyc(0, 0, 0, 0, 1, 1, 0, "R2");
        cyc(0, 0, 0, 0, 0, 1, 0, "R3");
        cyc(0, 0, 0, 0, 0, 1, 0, "R3");

        // R9: fifo_level ignored in character mode
        cyc(0, 0, 0, 0, 0, 0, 20, "R9");
        cyc(0, 0, 0, 0, 1, 0, 0, "R9");
        cyc(0, 0, 0, 0, 0, 0, 0, "R9");
        cyc(0, 0, 0, 0, 0, 0, 31, "R9");

        // R6: delayed host set, then expiry
        cyc(0, 0, 1, 5, 0, 1, 0, "R6");
        repeat (6) cyc(0, 0, 1, 5, 0, 0, 0, "R6");
        // R7: write cancels pending set
        cyc(0, 0, 1, 4, 1, 0, 0, "R7");
        cyc(0, 0, 1, 4, 0, 1, 0, "R7");
        cyc(0, 0, 1, 4, 0, 0, 0, "R7");
        cyc(0, 0, 1, 4, 1, 0, 0, "R7");
        repeat (6) cyc(0, 0, 1, 4, 0, 0, 0, "R7");
        // R6: zero length means no delay
        cyc(0, 0, 1, 0, 1, 0, 0, "R6");
        cyc(0, 0, 1, 0, 0, 1, 0, "R6");

        // R4 / R5: FIFO mode, each trigger level
        for (int s = 0; s < 4; s++) begin
            cyc(1, 2'(s), 0, 0, 0, 0, 0, "R4");
            for (int l = 1; l < trig_of(2'(s)); l++)
                cyc(1, 2'(s), 0, 0, 1, 0, l, "R5");
            cyc(1, 2'(s), 0, 0, 1, 0, trig_of(2'(s)), "R5");
            cyc(1, 2'(s), 0, 0, 0, 1, 1, "R5");
            cyc(1, 2'(s), 0, 0, 0, 1, 0, "R4");
        end
        // R9: strobes ignored in FIFO mode
        cyc(1, 1, 0, 0, 1, 0, 2, "R9");
        cyc(1, 1, 0, 0, 1, 1, 3, "R9");
        cyc(1, 1, 0, 0, 0, 0, 6, "R9");
        cyc(1, 1, 0, 0, 0, 1, 5, "R9");
        cyc(1, 1, 0, 0, 1, 1, 2, "R9");
        // R7: reaching trigger cancels pending set in FIFO mode
        cyc(1, 1, 1, 6, 0, 0, 0, "R7");
        cyc(1, 1, 1, 6, 0, 0, 2, "R7");
        cyc(1, 1, 1, 6, 0, 0, 4, "R7");
        repeat (8) cyc(1, 1, 1, 6, 0, 0, 4, "R7");
        // R6: FIFO-mode delay runs to expiry
        cyc(1, 1, 1, 3, 0, 0, 0, "R6");
        repeat (4) cyc(1, 1, 1, 3, 0, 0, 1, "R6");

        // Random phases alternating the two modes
        lvl = 1;
        for (int ph = 0; ph < 8; ph++) begin
            bit         fm = ph[0];
            logic [1:0] ts = 2'($urandom_range(0, 3));
            bit         te = 1'($urandom_range(0, 1));
            int         tl = $urandom_range(0, 7);
            for (int i = 0; i < 400; i++) begin
                bit wr = 1'($urandom_range(0, 1));
                bit rd = 1'($urandom_range(0, 1));
                if (fm) begin
                    if (wr && lvl < 16) lvl++;
                    if (rd && lvl > 0 && $urandom_range(0, 2) != 0) lvl--;
                    cyc(fm, ts, te, tl, wr, rd, lvl, "R5");
                end else begin
                    cyc(fm, ts, te, tl, wr && ($urandom_range(0, 3) == 0), rd,
                        $urandom_range(0, 31), "R3");
                end
            end
        end
        finish_run();
    end

endmodule